// File: doc/BRIEF.md
# Codec Serial Port with Primary and Secondary Frames

This block is the digital side of a codec's synchronous serial link to a DSP. Each frame moves one 16-bit word in each direction, most significant bit first. In a primary frame the port sends an ADC sample and receives a DAC sample. In a secondary frame it receives a control word that either writes one register of a small bank or reads one back, and the read data leaves on the same frame's output. The design clock is the serial bit clock, so one cycle carries one bit. A primary frame begins on a one-cycle frame-start strobe, which is the detected falling edge of the frame sync. The output line is driven only while a word is being shifted. At all other times its enable is low and the line itself is held low.

A secondary frame is requested either at the end of a primary frame or through the hardware request pin. In 15+1 format the request is the received word's bit 0. The hardware request pin works in both formats. The secondary frame begins exactly half a frame period after the primary strobe. At that moment the port pulses its own secondary-sync output and starts shifting. The master/slave state is embedded in both outgoing word types. Register 1 bit 0 selects between the full 16-bit DAC format and the 15+1 format.

Top module: `codec_port`

## Requirements
- R1: The cycle after `fs_strobe` is sampled high (or after an internal secondary start), `dout_en` goes high and stays high for exactly 16 cycles, then goes low. While `dout_en` is low, `dout` is 0.
- R2: A primary frame sends `{adc_sample[15:1], ms_mode}`, MSB first, one bit per cycle, with `adc_sample` and `ms_mode` captured at the start edge.
- R3: A secondary frame sends `ms_mode` as bit 15 and zeros in bits 14:8. Bits 7:0 are zero unless a read is requested.
- R4: In a secondary input word, bit 12 = 1 marks a read, and bits 11:8 hold the address. The addressed register's byte is sent on output bits 7:0 of the same frame. Addresses at or above the bank size (8) return zero.
- R5: A secondary input word with bit 12 = 0 writes bits 7:0 to the register at address bits 11:8 when the frame ends. A write to an address at or above 8 leaves the whole bank unchanged.
- R6: The cycle after the 16th bit of a primary frame, `dac_strobe` pulses for one cycle and `dac_sample` holds the received word. In 15+1 format, bit 0 of that word is forced to 0.
- R7: A secondary frame is requested when `fc` is high during the last bit cycle of a primary frame. In 15+1 format (register 1 bit 0 = 1) it is also requested when received bit 0 is 1. In 16-bit format, bit 0 never requests one.
- R8: When a secondary frame is requested, `sec_fs` pulses and `dout_en` rises exactly 128 cycles after the cycle in which the primary frame's first output bit appeared. Without a request, neither happens.
- R9: A primary `fs_strobe` in the same cycle as a pending secondary start takes priority, and the pending request is discarded.
- R10: After reset, `dout_en`, `dout`, `dac_sample`, `dac_strobe`, `sec_fs` and every register are 0, and the format is 16-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_strobe | input | 1 | One-cycle primary frame start |
| din | input | 1 | Serial data in, MSB first |
| fc | input | 1 | Hardware secondary-frame request, tie low if unused |
| ms_mode | input | 1 | Master/slave pin state |
| adc_sample | input | 16 | Parallel ADC result |
| dout | output | 1 | Serial data out |
| dout_en | output | 1 | Output enable for dout (low = released) |
| sec_fs | output | 1 | Pulse marking a secondary frame start |
| dac_sample | output | 16 | Last primary word received |
| dac_strobe | output | 1 | One-cycle pulse when dac_sample updates |
| reg_bank | output | 64 | Register bank, register i at bits 8i+7:8i |

## Verification
Two events can fall in the same cycle here: a new primary strobe and the internally timed secondary start. The bench requests a secondary frame and then drives `fs_strobe` in exactly cycle 128. It judges the outcome by three things: the following word must be the ADC sample, `sec_fs` must stay low, and no secondary frame may appear later. A second overlap sits inside a secondary read. The register byte must be spliced into the outgoing word mid-frame while input bits are still arriving. This is judged by reading back a value written in an earlier secondary frame.

// File: rtl/codec_port_pkg.sv
package codec_port_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int RD_BIT = 12;

  function automatic logic [WORD_W-1:0] prim_tx_word(logic [WORD_W-1:0] adc, logic ms);
    return {adc[WORD_W-1:1], ms};
  endfunction

  function automatic logic [WORD_W-1:0] sec_tx_head(logic ms);
    return {ms, {(WORD_W-1){1'b0}}};
  endfunction

  function automatic logic [WORD_W-1:0] dac_from_din(logic [WORD_W-1:0] w, logic fmt15);
    return fmt15 ? {w[WORD_W-1:1], 1'b0} : w;
  endfunction

  function automatic logic sec_requested(logic [WORD_W-1:0] w, logic fc, logic fmt15);
    return fc | (fmt15 & w[0]);
  endfunction
endpackage

// File: rtl/codec_shifter.sv
module codec_shifter #(
  parameter int W = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  start_word,
  input  logic          reload,
  input  logic [BW-1:0] reload_byte,
  input  logic          din,
  output logic          dout,
  output logic          dout_en,
  output logic          mid,
  output logic [BW-1:0] head,
  output logic          last,
  output logic [W-1:0]  full
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] MIDC = CW'(W - BW);

  logic          active;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;
  logic [W-1:0]  rx;

  assign last    = active && (cnt == '0);
  assign mid     = active && (cnt == MIDC);
  assign head    = {rx[BW-2:0], din};
  assign full    = {rx[W-2:0], din};
  assign dout_en = active;
  assign dout    = active & sh[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      rx     <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= CW'(W - 1);
      sh     <= start_word;
    end else if (active) begin
      cnt <= cnt - 1'b1;
      rx  <= full;
      sh  <= (mid && reload) ? {reload_byte, {(W-BW){1'b0}}} : {sh[W-2:0], 1'b0};
      if (last) active <= 1'b0;
    end
  end
endmodule

// File: rtl/codec_sequencer.sv
module codec_sequencer #(
  parameter int HALF = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_strobe,
  input  logic req_set,
  output logic sec_start,
  output logic sec_frame
);
  localparam int PW = $clog2(HALF + 1);
  localparam logic [PW-1:0] HALFC = PW'(HALF);

  logic [PW-1:0] ph;
  logic          pend;

  assign sec_start = pend && (ph == HALFC) && !fs_strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= '0;
      pend      <= 1'b0;
      sec_frame <= 1'b0;
    end else begin
      if (fs_strobe)        ph <= PW'(1);
      else if (ph == HALFC) ph <= '0;
      else if (ph != '0)    ph <= ph + 1'b1;

      if (fs_strobe)      pend <= 1'b0;
      else if (req_set)   pend <= 1'b1;
      else if (sec_start) pend <= 1'b0;

      if (fs_strobe)      sec_frame <= 1'b0;
      else if (sec_start) sec_frame <= 1'b1;
    end
  end
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile #(
  parameter int NREG = 8,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [DW-1:0]      wdata,
  input  logic [AW-1:0]      raddr,
  output logic [DW-1:0]      rdata,
  output logic [NREG*DW-1:0] bank
);
  logic [DW-1:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                         mem[i] <= '0;
      else if (we && waddr == AW'(i))     mem[i] <= wdata;
    end
    assign bank[i*DW +: DW] = mem[i];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (raddr == AW'(i)) rdata = mem[i];
  end
endmodule

// File: rtl/codec_port.sv
module codec_port
  import codec_port_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW = 4,
  parameter int HALF = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fs_strobe,
  input  logic                  din,
  input  logic                  fc,
  input  logic                  ms_mode,
  input  logic [WORD_W-1:0]     adc_sample,
  output logic                  dout,
  output logic                  dout_en,
  output logic                  sec_fs,
  output logic [WORD_W-1:0]     dac_sample,
  output logic                  dac_strobe,
  output logic [NREG*BYTE_W-1:0] reg_bank
);
  logic              sec_start, sec_frame, start;
  logic              mid, last, prim_last, req_set, we;
  logic [BYTE_W-1:0] head, rdata;
  logic [WORD_W-1:0] full, start_word;
  logic              fmt15;

  assign fmt15      = reg_bank[BYTE_W];
  assign start      = fs_strobe | sec_start;
  assign start_word = sec_start ? sec_tx_head(ms_mode) : prim_tx_word(adc_sample, ms_mode);
  assign prim_last  = last && !sec_frame;
  assign req_set    = prim_last && sec_requested(full, fc, fmt15);
  assign we         = last && sec_frame && !full[RD_BIT];

  codec_shifter #(.W(WORD_W), .BW(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .start_word(start_word),
    .reload(sec_frame && head[RD_BIT-BYTE_W]), .reload_byte(rdata),
    .din(din), .dout(dout), .dout_en(dout_en), .mid(mid), .head(head),
    .last(last), .full(full)
  );

  codec_sequencer #(.HALF(HALF)) u_seq (
    .clk(clk), .rst_n(rst_n), .fs_strobe(fs_strobe), .req_set(req_set),
    .sec_start(sec_start), .sec_frame(sec_frame)
  );

  codec_regfile #(.NREG(NREG), .AW(AW), .DW(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(full[BYTE_W+AW-1:BYTE_W]),
    .wdata(full[BYTE_W-1:0]), .raddr(head[AW-1:0]), .rdata(rdata), .bank(reg_bank)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_sample <= '0;
      dac_strobe <= 1'b0;
      sec_fs     <= 1'b0;
    end else begin
      dac_strobe <= prim_last;
      sec_fs     <= sec_start;
      if (prim_last) dac_sample <= dac_from_din(full, fmt15);
    end
  end
endmodule

// File: rtl/codec_port_chk.sv
module codec_port_chk (
  input logic clk,
  input logic rst_n,
  input logic fs_strobe,
  input logic sec_start,
  input logic dout,
  input logic dout_en,
  input logic sec_fs,
  input logic ms_mode,
  input logic adc_msb,
  input logic dac_strobe
);
  // R1
  en_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_en) |-> ($past(fs_strobe) || $past(sec_start)));
  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> !dout);
  // R2
  prim_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dout_en) && !sec_fs) |-> (dout == $past(adc_msb)));
  // R3
  sec_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_fs |-> (dout_en && dout == $past(ms_mode)));
  // R6
  dac_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_strobe |-> $fell(dout_en));
  // R9
  prim_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_strobe |=> (dout_en && !sec_fs));
endmodule

bind codec_port codec_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fs_strobe(fs_strobe), .sec_start(sec_start),
  .dout(dout), .dout_en(dout_en), .sec_fs(sec_fs), .ms_mode(ms_mode),
  .adc_msb(adc_sample[15]), .dac_strobe(dac_strobe)
);

// File: tb/codec_port_bench.sv
module codec_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs_strobe = 1'b0, din = 1'b0, fc = 1'b0, ms_mode = 1'b0;
  logic [15:0] adc_sample = '0;
  logic        dout, dout_en, sec_fs, dac_strobe;
  logic [15:0] dac_sample;
  logic [63:0] reg_bank;
  logic [63:0] exp_bank = '0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  codec_port u_codec_port (
    .clk(clk), .rst_n(rst_n), .fs_strobe(fs_strobe), .din(din), .fc(fc),
    .ms_mode(ms_mode), .adc_sample(adc_sample), .dout(dout), .dout_en(dout_en),
    .sec_fs(sec_fs), .dac_sample(dac_sample), .dac_strobe(dac_strobe), .reg_bank(reg_bank)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at the negedge right after the start edge; returns at the negedge after bit 16.
  task automatic shift_word(input logic [15:0] din_w, input logic [15:0] exp_w, input bit fc_last, input string tag);
    logic [15:0] got = '0;
    bit en_ok = 1;
    for (int k = 0; k < 16; k++) begin
      fs_strobe = 1'b0;
      got[15-k] = dout;
      if (!dout_en) en_ok = 0;
      din = din_w[15-k];
      fc  = (k == 15) ? fc_last : 1'b0;
      @(negedge clk);
    end
    fc = 1'b0; din = 1'b0;
    chk(en_ok, {tag, " R1 enable held 16 cycles"}, 64'(en_ok), 64'd1);
    chk(got == exp_w, {tag, " word out"}, 64'(got), 64'(exp_w));
    chk(!dout_en && !dout, {tag, " R1 released"}, 64'({dout_en, dout}), 64'd0);
  endtask

  task automatic primary(input logic [15:0] adc, input logic ms, input logic [15:0] din_w,
                         input bit fc_last, input bit fmt15, input string tag);
    logic [15:0] exp_dac;
    adc_sample = adc; ms_mode = ms;
    fs_strobe = 1'b1;
    @(negedge clk);
    shift_word(din_w, {adc[15:1], ms}, fc_last, {tag, " R2 primary"});
    exp_dac = fmt15 ? {din_w[15:1], 1'b0} : din_w;
    chk(dac_strobe == 1'b1, {tag, " R6 strobe"}, 64'(dac_strobe), 64'd1);
    chk(dac_sample == exp_dac, {tag, " R6 dac"}, 64'(dac_sample), 64'(exp_dac));
  endtask

  // Called at the negedge after a requesting primary (n16); runs the secondary frame.
  task automatic secondary(input logic [15:0] din_w, input logic [15:0] exp_w, input string tag);
    repeat (111) @(negedge clk);
    chk(!sec_fs && !dout_en, {tag, " R8 not early"}, 64'({sec_fs, dout_en}), 64'd0);
    @(negedge clk);
    chk(sec_fs && dout_en, {tag, " R8 start at 128"}, 64'({sec_fs, dout_en}), 64'd3);
    shift_word(din_w, exp_w, 1'b0, {tag, " R3 secondary"});
  endtask

  task automatic expect_quiet(input int n, input string tag);
    bit quiet = 1;
    for (int k = 0; k < n; k++) begin
      if (sec_fs || dout_en) quiet = 0;
      @(negedge clk);
    end
    chk(quiet, {tag, " no secondary frame"}, 64'(quiet), 64'd1);
  endtask

  task automatic t_reset;
    chk(!dout_en && !dout && !sec_fs && !dac_strobe, "R10 outputs idle", 64'({dout_en, dout, sec_fs, dac_strobe}), 64'd0);
    chk(dac_sample == '0 && reg_bank == '0, "R10 dac and bank zero", {dac_sample, reg_bank[47:0]}, 64'd0);
  endtask

  task automatic t_prim16;
    // 16-bit format: D0=1 is data only, must not request (R7)
    primary(16'h1234, 1'b1, 16'hBEEF, 1'b0, 1'b0, "T16");
    expect_quiet(140, "T16 R7 bit0 ignored");
  endtask

  task automatic t_fc_write_fmt;
    primary(16'hA5C2, 1'b1, 16'h0F0E, 1'b1, 1'b0, "TFC R7 fc");
    secondary(16'h0101, 16'h8000, "TFC R5 write r1");
    exp_bank[15:8] = 8'h01;
    chk(reg_bank == exp_bank, "TFC R5 bank", reg_bank, exp_bank);
  endtask

  task automatic t_inband_write;
    primary(16'hFFFF, 1'b0, 16'h4321, 1'b0, 1'b1, "TIB R7 bit0");
    secondary(16'h035A, 16'h0000, "TIB R5 write r3");
    exp_bank[31:24] = 8'h5A;
    chk(reg_bank == exp_bank, "TIB R5 bank", reg_bank, exp_bank);
  endtask

  task automatic t_read;
    primary(16'h0F00, 1'b0, 16'h0001, 1'b0, 1'b1, "TRD");
    secondary(16'h1300, 16'h005A, "TRD R4 read r3");
    chk(reg_bank == exp_bank, "TRD R4 read leaves bank", reg_bank, exp_bank);
    primary(16'h0F00, 1'b1, 16'h0001, 1'b0, 1'b1, "TRD2");
    secondary(16'h1C00, 16'h8000, "TRD2 R4 read addr 12 zero");
  endtask

  task automatic t_bad_write;
    primary(16'h7777, 1'b1, 16'h0003, 1'b0, 1'b1, "TBW");
    secondary(16'h0CFF, 16'h8000, "TBW R5 out of range");
    chk(reg_bank == exp_bank, "TBW R5 bank unchanged", reg_bank, exp_bank);
  endtask

  task automatic t_collide;
    primary(16'h2468, 1'b0, 16'h0001, 1'b0, 1'b1, "TCO");
    repeat (111) @(negedge clk);
    fs_strobe = 1'b1;
    @(negedge clk);
    chk(!sec_fs, "TCO R9 no sec_fs", 64'(sec_fs), 64'd0);
    shift_word(16'h1110, {16'h9BDE & 16'hFFFE, 1'b0} >> 1 == 0 ? 16'h0 : 16'h2468, 1'b0, "TCO R9 primary wins");
    expect_quiet(140, "TCO R9 request dropped");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_prim16();
    t_fc_write_fmt();
    t_inband_write();
    t_read();
    t_bad_write();
    t_collide();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule